// File: doc/BRIEF.md
# Power-Switch Fault Qualifier and Latch

This block guards each power port of a supply controller against a damaged or misbehaving pass switch. The analog front end supplies one already-qualified raw flag per port, which is high while it sees an abnormal switch condition such as an over-driven gate or a drain-to-source short. The block counts how long that flag stays high without a break. Once the condition lasts longer than a qualification time, the block declares a persistent fault for that port.

A declared fault is sticky. It forces the port off, selects the reduced pull-down strength in the gate driver, and emits a one-cycle event pulse that a register file uses to set its switch-fault status bit. The fault clears only through that port's clear strobe or through the chip-wide clear. If the condition is still present after a clear, the port must pass a full new qualification window before the fault latches again. Ports are replicated by a parameter and share nothing except the chip-wide clear.

Top module: `fet_fault_guard`

## Requirements
- R1: For a port, the fault latches only when its condition flag is sampled high on more than QUAL_CYC consecutive rising clock edges, where QUAL_CYC = CLK_HZ*QUAL_NS/1e9. With exactly QUAL_CYC high samples it does not latch. With QUAL_CYC+1 high samples the outputs are high just after the last of those edges.
- R2: If the condition flag is sampled low before the window expires, the count restarts from zero, and a later run needs QUAL_CYC+1 fresh high samples.
- R3: While a port's fault is latched, its port-off output is 1.
- R4: While a port's fault is latched, its reduced-pulldown select output is 1.
- R5: The fault-event output is high for exactly one cycle, the first cycle in which the fault is latched.
- R6: A latched fault stays latched after the condition flag goes low, for as long as no clear arrives.
- R7: A port-clear strobe sampled high clears that port's fault at that edge. If the condition is still high, the fault re-latches only after QUAL_CYC+1 further high samples counted from the edge after the clear.
- R8: A chip-clear strobe sampled high clears the fault on every port at that edge.
- R9: A port clear and a chip clear in the same cycle act as a single clear, with the same outcome and the same re-qualification timing as either strobe alone.
- R10: The condition flag and the clear strobe of one port have no effect on the outputs of any other port.
- R11: After reset, all outputs are 0.
- R12: If no port's condition flag is ever high, no output ever becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| port_clr_i | input | NUM_PORTS | Per-port clear strobe |
| chip_clr_i | input | 1 | Clear strobe for all ports |
| cond_i | input | NUM_PORTS | Qualified raw switch-fault condition per port |
| port_off_o | output | NUM_PORTS | Disable all functions of the port |
| weak_pulldn_o | output | NUM_PORTS | Select the reduced gate pull-down current |
| fault_evt_o | output | NUM_PORTS | One-cycle fault event pulse for the register file |

## Verification
The assertions assume that the condition and clear inputs are synchronous to the block clock and settle well before each rising edge. They also assume that a clear is a level sampled at one edge, not an edge that has to be detected. The bench meets these assumptions by changing every input only on falling edges and by holding each clear strobe for exactly one rising edge. Because the bench overrides the qualification time to a short window, it can count every boundary sample exactly.

// File: rtl/fetflt_pkg.sv
package fetflt_pkg;

  typedef enum logic {
    FF_CLEAN   = 1'b0,
    FF_TRIPPED = 1'b1
  } ff_state_e;

  // Converts a duration to a cycle count at a given clock rate (at least 1).
  function automatic int unsigned cyc_from_ns(input longint unsigned hz,
                                              input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/fetflt_clear_join.sv
module fetflt_clear_join #(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] port_clr_i,
  input  logic                 chip_clr_i,
  output logic [NUM_PORTS-1:0] clr_o
);

  // Both sources merge into a single clear per port.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_join
    always_comb clr_o[g] = port_clr_i[g] | chip_clr_i;
  end

endmodule

// File: rtl/fetflt_qual_timer.sv
module fetflt_qual_timer #(
  parameter int unsigned QUAL_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic hold_i,
  output logic expire_o
);

  localparam int unsigned CW  = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_max;

  always_comb begin
    at_max = (cnt_q == CMAX);
    if (hold_i || !cond_i) begin
      cnt_d = '0;
    end else if (!at_max) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    cnt_en   = (cnt_d != cnt_q);
    expire_o = cond_i & ~hold_i & at_max;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_restart_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> (cnt_q == '0));

  p_hold_zero_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));

  p_no_overflow_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);

endmodule

// File: rtl/fetflt_trip_latch.sv
module fetflt_trip_latch
  import fetflt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic tripped_o,
  output logic evt_o
);

  ff_state_e state_q, state_d;
  logic      evt_q, evt_d;
  logic      state_en;

  always_comb begin
    state_d = state_q;
    if (clr_i) begin
      state_d = FF_CLEAN;
    end else if (set_i) begin
      state_d = FF_TRIPPED;
    end
    evt_d    = (state_q == FF_CLEAN) && (state_d == FF_TRIPPED);
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FF_CLEAN;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
    end
  end

  assign tripped_o = (state_q == FF_TRIPPED);
  assign evt_o     = evt_q;

  p_sticky_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FF_TRIPPED) && !clr_i |=> (state_q == FF_TRIPPED));

  p_clear_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_q == FF_CLEAN));

  p_evt_single_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);

  p_evt_entry_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (state_q == FF_TRIPPED));

endmodule

// File: rtl/fet_fault_guard.sv
module fet_fault_guard
  import fetflt_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned QUAL_NS   = 180_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] port_clr_i,
  input  logic                 chip_clr_i,
  input  logic [NUM_PORTS-1:0] cond_i,
  output logic [NUM_PORTS-1:0] port_off_o,
  output logic [NUM_PORTS-1:0] weak_pulldn_o,
  output logic [NUM_PORTS-1:0] fault_evt_o
);

  localparam int unsigned QUAL_CYC = cyc_from_ns(longint'(CLK_HZ), longint'(QUAL_NS));

  logic [NUM_PORTS-1:0] clr;
  logic [NUM_PORTS-1:0] expire;
  logic [NUM_PORTS-1:0] tripped;
  logic [NUM_PORTS-1:0] hold;

  fetflt_clear_join #(.NUM_PORTS(NUM_PORTS)) u_clear_join (
    .port_clr_i (port_clr_i),
    .chip_clr_i (chip_clr_i),
    .clr_o      (clr)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // The timer sits idle while the port is tripped or being cleared.
    always_comb hold[p] = clr[p] | tripped[p];

    fetflt_qual_timer #(.QUAL_CYC(QUAL_CYC)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cond_i   (cond_i[p]),
      .hold_i   (hold[p]),
      .expire_o (expire[p])
    );

    fetflt_trip_latch u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (expire[p]),
      .clr_i     (clr[p]),
      .tripped_o (tripped[p]),
      .evt_o     (fault_evt_o[p])
    );

    always_comb begin
      port_off_o[p]    = tripped[p];
      weak_pulldn_o[p] = tripped[p];
    end

    p_rise_needs_cond_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(port_off_o[p]) |-> $past(cond_i[p]));

    p_evt_with_off_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_evt_o[p] |-> (port_off_o[p] && weak_pulldn_o[p]));
  end

  p_chip_clear_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_clr_i |=> (port_off_o == '0));

endmodule

// File: tb/fet_fault_guard_bench.sv
module fet_fault_guard_bench;

  localparam int NP     = 4;
  localparam int B_QUAL = 50;   // 125 MHz * 400 ns

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] port_clr = '0;
  logic          chip_clr = 1'b0;
  logic [NP-1:0] cond = '0;
  logic [NP-1:0] port_off, weak_pd, evt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fet_fault_guard #(.NUM_PORTS(NP), .CLK_HZ(125_000_000), .QUAL_NS(400)) u_fet_fault_guard (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .port_clr_i    (port_clr),
    .chip_clr_i    (chip_clr),
    .cond_i        (cond),
    .port_off_o    (port_off),
    .weak_pulldn_o (weak_pd),
    .fault_evt_o   (evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 off", 32'(port_off), 0);
    chk("R11 weak", 32'(weak_pd), 0);
    chk("R11 evt", 32'(evt), 0);
  endtask

  task automatic t_quiet();
    logic [NP-1:0] seen = '0;
    for (int i = 0; i < 100; i++) begin
      step(1);
      seen |= port_off | weak_pd | evt;
    end
    chk("R12 no output without condition", 32'(seen), 0);
  endtask

  task automatic t_short();
    cond[0] = 1'b1;
    step(B_QUAL);
    chk("R1 exactly QUAL samples no latch", 32'(port_off[0]), 0);
    cond[0] = 1'b0;
    step(2);
    chk("R1 still clear after drop", 32'(port_off[0]), 0);
  endtask

  task automatic t_exact();
    cond[0] = 1'b1;
    step(B_QUAL + 1);
    chk("R1 latch after QUAL+1", 32'(port_off[0]), 1);
    chk("R3 port off", 32'(port_off[0]), 1);
    chk("R4 weak pulldown", 32'(weak_pd[0]), 1);
    chk("R5 event first cycle", 32'(evt[0]), 1);
    chk("R10 other ports untouched", 32'(port_off[NP-1:1]), 0);
    cond[0] = 1'b0;
    step(1);
    chk("R5 event only one cycle", 32'(evt[0]), 0);
  endtask

  task automatic t_sticky();
    step(20);
    chk("R6 stays latched", 32'(port_off[0]), 1);
    chk("R6 weak stays", 32'(weak_pd[0]), 1);
    chk("R5 no repeat event", 32'(evt[0]), 0);
  endtask

  task automatic t_port_clear();
    cond[1] = 1'b1;
    step(B_QUAL + 1);
    chk("R1 port1 latched", 32'(port_off[1]), 1);
    cond[1] = 1'b0;
    port_clr[0] = 1'b1;
    step(1);
    port_clr[0] = 1'b0;
    chk("R7 port0 cleared", 32'(port_off[0]), 0);
    chk("R7 port0 weak cleared", 32'(weak_pd[0]), 0);
    chk("R10 port1 unaffected by port0 clear", 32'(port_off[1]), 1);
    port_clr[1] = 1'b1;
    step(1);
    port_clr[1] = 1'b0;
    chk("R7 port1 cleared", 32'(port_off[1]), 0);
  endtask

  task automatic t_restart();
    cond[3] = 1'b1;
    step(B_QUAL - 5);
    cond[3] = 1'b0;
    step(1);
    cond[3] = 1'b1;
    step(B_QUAL);
    chk("R2 restarted count not expired", 32'(port_off[3]), 0);
    step(1);
    chk("R2 latch after fresh window", 32'(port_off[3]), 1);
    cond[3] = 1'b0;
    port_clr[3] = 1'b1;
    step(1);
    port_clr[3] = 1'b0;
    chk("R7 port3 cleared", 32'(port_off[3]), 0);
  endtask

  task automatic t_relatch();
    cond[2] = 1'b1;
    step(B_QUAL + 1);
    chk("R1 port2 latched", 32'(port_off[2]), 1);
    port_clr[2] = 1'b1;
    step(1);
    port_clr[2] = 1'b0;
    chk("R7 cleared under live condition", 32'(port_off[2]), 0);
    step(B_QUAL);
    chk("R7 no early relatch", 32'(port_off[2]), 0);
    step(1);
    chk("R7 relatch after new window", 32'(port_off[2]), 1);
    chk("R5 event on relatch", 32'(evt[2]), 1);
    cond[2] = 1'b0;
  endtask

  task automatic t_chip();
    cond = '1;
    step(B_QUAL + 1);
    chk("R1 all latched", 32'(port_off), 32'({NP{1'b1}}));
    cond = '0;
    chip_clr = 1'b1;
    step(1);
    chip_clr = 1'b0;
    chk("R8 chip clear all off", 32'(port_off), 0);
    chk("R8 chip clear all weak", 32'(weak_pd), 0);
  endtask

  task automatic t_both();
    cond[1] = 1'b1;
    step(B_QUAL + 1);
    chk("R1 port1 latched again", 32'(port_off[1]), 1);
    port_clr[1] = 1'b1;
    chip_clr = 1'b1;
    step(1);
    port_clr[1] = 1'b0;
    chip_clr = 1'b0;
    chk("R9 joint clear", 32'(port_off[1]), 0);
    step(B_QUAL);
    chk("R9 single window no early relatch", 32'(port_off[1]), 0);
    step(1);
    chk("R9 relatch timing as single clear", 32'(port_off[1]), 1);
    chk("R10 others stay clear", 32'({port_off[3:2], port_off[0]}), 0);
    cond[1] = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_quiet();
    t_short();
    t_exact();
    t_sticky();
    t_port_clear();
    t_restart();
    t_relatch();
    t_chip();
    t_both();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule